// File: doc/BRIEF.md
# Flash Block Lock Command Controller

This block decodes the two-write command sequences that protect blocks of a parallel flash array. A setup write followed by a confirm write either sets the protection bit of one block or releases every block in one operation. The block holds one protection bit per block. Erase and program requests from the rest of the chip are checked against these bits, and a permit is given only when the target block is free.

The protection bits model nonvolatile cells. They have no reset, so a logic reset leaves them unchanged. After a setup write the read path is switched to the status register. A protection change keeps the block busy for a parameterised number of cycles, and during that time the ready bit and the ready pin are low. A change is refused while the array is programming, erasing or suspended. It is also refused while the programming supply is invalid, and in that case an error bit is raised. The index of the target block comes from the upper address bits.

Top module: `flash_lock_ctrl`

## Requirements
- R1: A write of 0x60 followed by a write of 0x01 sets the protection bit of the block named by the upper BLK_W address bits of the confirm write. Other bits do not change.
- R2: A write of 0x60 followed by a write of 0xD0, to any address, clears every protection bit at once.
- R3: An accepted 0x60 write sets rd_status_sel from the next cycle. A write of 0xFF while idle clears it.
- R4: Status bit 7 and ready go low on the cycle after an accepted confirm and stay low for exactly OP_CYCLES cycles. The protection change shows on the same edge that ready rises.
- R5: req_permit is high only when req_valid is high and the block named by the upper bits of req_addr is unprotected.
- R6: rst_n returns the status to 0x80 and rd_status_sel to 0. It leaves the protection bits unchanged.
- R7: A 0x60 write while busy_ext or suspended is high is ignored. Status mode is not entered, and a later confirm byte has no effect.
- R8: A confirm while vpp_ok is low changes no bit and does not go busy. It sets status bit 3, and also bit 4 for a 0x01 confirm or bit 5 for a 0xD0 confirm.
- R9: A confirm byte other than 0x01 or 0xD0 sets status bits 4 and 5, changes no bit, and returns to idle.
- R10: A 0x50 write while idle clears status bits 5..3. An accepted 0x60 write also clears them.
- R11: A confirm arriving while busy_ext or suspended is high is refused. It sets status bits 4 and 5 and changes no bit.
- R12: Writes that arrive while a protection change is in progress are ignored. Only the change already in progress is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset; does not affect protection bits |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; upper BLK_W bits select the block |
| wr_data | input | 8 | Command byte |
| vpp_ok | input | 1 | Programming supply above its lockout level |
| busy_ext | input | 1 | Array is programming or erasing |
| suspended | input | 1 | An erase or program is suspended |
| req_valid | input | 1 | An erase or program request is presented |
| req_addr | input | ADDR_W | Target address of the request |
| lock_bits | output | NUM_BLOCKS | Protection bit per block, 1 = protected |
| rd_status_sel | output | 1 | Read path returns the status register |
| status_reg | output | 8 | Bit 7 ready, bit 5 clear error, bit 4 set/sequence error, bit 3 supply error |
| ready | output | 1 | High when no protection change is in progress |
| req_permit | output | 1 | Request may proceed |

## Verification
The bench targets the block at both ends of the range (0 and 127), because an index slice taken from the wrong address bits would protect the wrong block. It counts the busy window cycle by cycle, which catches an off-by-one counter that makes ready rise early or applies the change a cycle late. It fires refused confirms under low supply, under suspend and with a bad byte. A design that wrote the bits anyway, or raised the wrong error pair, shows up in the bit vector or the status byte. It also pulses reset with blocks protected and sends extra writes in the middle of an operation. These expose bits that are wrongly reset and commands that are wrongly taken while busy.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BUSY  = 2'd2
    } lk_state_e;

    localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
    localparam logic [7:0] CMD_SET_CONF   = 8'h01;
    localparam logic [7:0] CMD_CLR_CONF   = 8'hD0;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

    // error field order: [2] status bit 5, [1] status bit 4, [0] status bit 3
    localparam logic [2:0] ERR_NONE    = 3'b000;
    localparam logic [2:0] ERR_SET_VPP = 3'b011;
    localparam logic [2:0] ERR_CLR_VPP = 3'b101;
    localparam logic [2:0] ERR_SEQ     = 3'b110;

endpackage

// File: rtl/flash_lock_cmd_fsm.sv
module flash_lock_cmd_fsm
    import flash_lock_pkg::*;
#(
    parameter int BLK_W      = 7,
    parameter int OP_CYCLES  = 8,
    localparam int CNT_W     = $clog2(OP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             vpp_ok,
    input  logic             busy_ext,
    input  logic             suspended,
    output logic             set_en,
    output logic             clr_all,
    output logic [BLK_W-1:0] set_idx,
    output logic             rd_status_sel,
    output logic [7:0]       status_reg
);

    typedef struct packed {
        lk_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk;
        logic             op_clr;
        logic             rd_sts;
        logic [2:0]       err;
        logic             rdy;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:     ST_IDLE,
        cnt:    '0,
        blk:    '0,
        op_clr: 1'b0,
        rd_sts: 1'b0,
        err:    ERR_NONE,
        rdy:    1'b1
    };

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

    ctl_t ctl_d, ctl_q;
    logic array_busy;

    assign array_busy = busy_ext | suspended;

    always_comb begin
        ctl_d   = ctl_q;
        set_en  = 1'b0;
        clr_all = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_en) begin
                    if (wr_data == CMD_LOCK_SETUP && !array_busy) begin
                        ctl_d.st     = ST_SETUP;
                        ctl_d.rd_sts = 1'b1;
                        ctl_d.err    = ERR_NONE;
                    end else if (wr_data == CMD_READ_ARRAY) begin
                        ctl_d.rd_sts = 1'b0;
                    end else if (wr_data == CMD_CLR_STATUS) begin
                        ctl_d.err = ERR_NONE;
                    end
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    ctl_d.st = ST_IDLE;
                    if (array_busy) begin
                        ctl_d.err = ERR_SEQ;
                    end else if (wr_data == CMD_SET_CONF) begin
                        if (vpp_ok) begin
                            ctl_d.st     = ST_BUSY;
                            ctl_d.cnt    = CNT_LOAD;
                            ctl_d.blk    = wr_blk;
                            ctl_d.op_clr = 1'b0;
                            ctl_d.rdy    = 1'b0;
                        end else begin
                            ctl_d.err = ERR_SET_VPP;
                        end
                    end else if (wr_data == CMD_CLR_CONF) begin
                        if (vpp_ok) begin
                            ctl_d.st     = ST_BUSY;
                            ctl_d.cnt    = CNT_LOAD;
                            ctl_d.op_clr = 1'b1;
                            ctl_d.rdy    = 1'b0;
                        end else begin
                            ctl_d.err = ERR_CLR_VPP;
                        end
                    end else begin
                        ctl_d.err = ERR_SEQ;
                    end
                end
            end
            ST_BUSY: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.rdy = 1'b1;
                    set_en    = !ctl_q.op_clr;
                    clr_all   = ctl_q.op_clr;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign set_idx       = ctl_q.blk;
    assign rd_status_sel = ctl_q.rd_sts;
    assign status_reg    = {ctl_q.rdy, 1'b0, ctl_q.err, 3'b000};

    assert_setup_sts_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && wr_en && wr_data == CMD_LOCK_SETUP && !array_busy)
        |=> rd_status_sel);

    assert_ready_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_reg[7]) |-> ($past(ctl_q.st) == ST_SETUP && $past(wr_en) && $past(vpp_ok)));

    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BUSY && ctl_q.cnt != '0) |=> (ctl_q.st == ST_BUSY && !status_reg[7]));

    assert_ignore_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && array_busy) |=> ctl_q.st == ST_IDLE);

    assert_vpp_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SETUP && wr_en && !array_busy && !vpp_ok &&
         (wr_data == CMD_SET_CONF || wr_data == CMD_CLR_CONF))
        |=> (status_reg[3] && status_reg[7] && ctl_q.st == ST_IDLE));

    assert_bad_confirm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SETUP && wr_en && wr_data != CMD_SET_CONF && wr_data != CMD_CLR_CONF)
        |=> (status_reg[5:4] == 2'b11 && ctl_q.st == ST_IDLE));

endmodule

// File: rtl/flash_lock_array.sv
module flash_lock_array #(
    parameter int NUM_BLOCKS = 128,
    parameter int BLK_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [BLK_W-1:0]      set_idx,
    input  logic                  clr_all,
    input  logic                  req_valid,
    input  logic [BLK_W-1:0]      req_blk,
    output logic [NUM_BLOCKS-1:0] lock_q,
    output logic                  req_permit
);

    logic [NUM_BLOCKS-1:0] lock_d;
    logic                  req_in_range;

    // protection cells: no reset, they keep their value through logic reset
    for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_cell
        always_comb begin
            lock_d[gi] = lock_q[gi];
            if (clr_all)
                lock_d[gi] = 1'b0;
            else if (set_en && set_idx == BLK_W'(gi))
                lock_d[gi] = 1'b1;
        end

        always_ff @(posedge clk) begin
            lock_q[gi] <= lock_d[gi];
        end
    end

    assign req_in_range = ({1'b0, req_blk} < (BLK_W + 1)'(NUM_BLOCKS));
    assign req_permit   = req_valid && req_in_range && !lock_q[req_blk];

    assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> lock_q[$past(set_idx)]);

    assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> lock_q == '0);

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_all) |=> $stable(lock_q));

    assert_permit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_q[req_blk]) |-> !req_permit);

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl #(
    parameter int NUM_BLOCKS = 128,
    parameter int ADDR_W     = 24,
    parameter int OP_CYCLES  = 8,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  vpp_ok,
    input  logic                  busy_ext,
    input  logic                  suspended,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  rd_status_sel,
    output logic [7:0]            status_reg,
    output logic                  ready,
    output logic                  req_permit
);

    logic [BLK_W-1:0] wr_blk;
    logic [BLK_W-1:0] req_blk;
    logic [BLK_W-1:0] set_idx;
    logic             set_en;
    logic             clr_all;
    logic             unused_low_bits;

    assign wr_blk          = wr_addr[ADDR_W-1 -: BLK_W];
    assign req_blk         = req_addr[ADDR_W-1 -: BLK_W];
    assign unused_low_bits = ^{wr_addr[ADDR_W-BLK_W-1:0], req_addr[ADDR_W-BLK_W-1:0]};

    flash_lock_cmd_fsm #(
        .BLK_W     (BLK_W),
        .OP_CYCLES (OP_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_blk        (wr_blk),
        .vpp_ok        (vpp_ok),
        .busy_ext      (busy_ext),
        .suspended     (suspended),
        .set_en        (set_en),
        .clr_all       (clr_all),
        .set_idx       (set_idx),
        .rd_status_sel (rd_status_sel),
        .status_reg    (status_reg)
    );

    flash_lock_array #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .set_idx    (set_idx),
        .clr_all    (clr_all),
        .req_valid  (req_valid),
        .req_blk    (req_blk),
        .lock_q     (lock_bits),
        .req_permit (req_permit)
    );

    assign ready = status_reg[7];

endmodule

// File: tb/flash_lock_ctrl_tb.sv
module flash_lock_ctrl_tb;

    localparam int NB  = 128;
    localparam int AW  = 24;
    localparam int OPC = 8;
    localparam int BW  = $clog2(NB);

    // {confirm byte[18:11], block[10:4], vpp[3], expected err bits 5..3 [2:0]}
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {8'h01, 7'd5,   1'b1, 3'b000},
        {8'h01, 7'd127, 1'b1, 3'b000},
        {8'h01, 7'd0,   1'b1, 3'b000},
        {8'h01, 7'd9,   1'b0, 3'b011},
        {8'hD0, 7'd3,   1'b0, 3'b101},
        {8'h77, 7'd2,   1'b1, 3'b110},
        {8'hD0, 7'd40,  1'b1, 3'b000},
        {8'h01, 7'd64,  1'b1, 3'b000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          vpp_ok = 1'b1;
    logic          busy_ext = 1'b0;
    logic          suspended = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [NB-1:0] lock_bits;
    logic          rd_status_sel;
    logic [7:0]    status_reg;
    logic          ready;
    logic          req_permit;

    logic [NB-1:0] exp_lock;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    flash_lock_ctrl #(.NUM_BLOCKS(NB), .ADDR_W(AW), .OP_CYCLES(OPC)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .vpp_ok        (vpp_ok),
        .busy_ext      (busy_ext),
        .suspended     (suspended),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .lock_bits     (lock_bits),
        .rd_status_sel (rd_status_sel),
        .status_reg    (status_reg),
        .ready         (ready),
        .req_permit    (req_permit)
    );

    function automatic logic [AW-1:0] blk_addr(input int b);
        return {BW'(b), 17'h0ABCD};
    endfunction

    task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset status", NB'(status_reg), NB'(8'h80));
        chk("R6 reset rd_status_sel", NB'(rd_status_sel), NB'(0));
        chk("R4 reset ready", NB'(ready), NB'(1));
        chk("R5 no request no permit", NB'(req_permit), NB'(0));

        // factory state: clear all
        wr(blk_addr(1), 8'h60);
        wr(blk_addr(1), 8'hD0);
        repeat (OPC) @(negedge clk);
        exp_lock = '0;
        chk("R2 initial clear", lock_bits, exp_lock);

        // table of command sequences
        for (int i = 0; i < NV; i++) begin
            logic [7:0] cb;
            int         bk;
            logic       vp;
            logic [2:0] er;
            bit         acc;
            string      tg;
            cb  = VEC[i][18:11];
            bk  = int'(VEC[i][10:4]);
            vp  = VEC[i][3];
            er  = VEC[i][2:0];
            acc = vp && (cb == 8'h01 || cb == 8'hD0);
            if (!vp && (cb == 8'h01 || cb == 8'hD0)) tg = "R8";
            else if (cb == 8'h01) tg = "R1";
            else if (cb == 8'hD0) tg = "R2";
            else tg = "R9";
            wr(blk_addr(bk), 8'h60);
            chk("R3 status mode after setup", NB'(rd_status_sel), NB'(1));
            vpp_ok = vp;
            wr(blk_addr(bk), cb);
            vpp_ok = 1'b1;
            if (acc) begin
                chk("R4 ready low after confirm", NB'(ready), NB'(0));
                repeat (OPC) @(negedge clk);
                if (cb == 8'h01) exp_lock[bk] = 1'b1;
                else exp_lock = '0;
            end
            chk({tg, " status"}, NB'(status_reg), NB'({1'b1, 1'b0, er, 3'b000}));
            chk({tg, " lock bits"}, lock_bits, exp_lock);
        end

        // R5 permit gating
        req_valid = 1'b1; req_addr = blk_addr(64);
        #1 chk("R5 locked block denied", NB'(req_permit), NB'(0));
        req_addr = blk_addr(63);
        #1 chk("R5 free block permitted", NB'(req_permit), NB'(1));
        req_valid = 1'b0;
        #1 chk("R5 no valid no permit", NB'(req_permit), NB'(0));

        // R6 reset keeps lock bits
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R6 lock bits survive reset", lock_bits, exp_lock);
        chk("R6 status after reset", NB'(status_reg), NB'(8'h80));
        chk("R6 rd_status_sel after reset", NB'(rd_status_sel), NB'(0));

        // R4 exact busy window
        wr(blk_addr(10), 8'h60);
        wr(blk_addr(10), 8'h01);
        repeat (OPC - 1) @(negedge clk);
        chk("R4 ready still low at last busy cycle", NB'(ready), NB'(0));
        chk("R4 bit not yet applied", NB'(lock_bits[10]), NB'(0));
        @(negedge clk);
        exp_lock[10] = 1'b1;
        chk("R4 ready high after window", NB'(ready), NB'(1));
        chk("R4 bit applied with ready", lock_bits, exp_lock);

        // R12 writes during busy ignored
        wr(blk_addr(7), 8'h60);
        wr(blk_addr(7), 8'hD0);
        wr(blk_addr(20), 8'h60);
        wr(blk_addr(20), 8'h01);
        repeat (OPC - 2) @(negedge clk);
        exp_lock = '0;
        chk("R12 only clear applied", lock_bits, exp_lock);
        chk("R12 status clean", NB'(status_reg), NB'(8'h80));
        wr(blk_addr(20), 8'h01);
        chk("R12 stray confirm after idle", lock_bits, exp_lock);

        // R3 read array, R7 setup refused while busy or suspended
        wr(blk_addr(0), 8'hFF);
        chk("R3 read array clears status mode", NB'(rd_status_sel), NB'(0));
        busy_ext = 1'b1;
        wr(blk_addr(30), 8'h60);
        busy_ext = 1'b0;
        chk("R7 setup ignored while busy", NB'(rd_status_sel), NB'(0));
        wr(blk_addr(30), 8'h01);
        chk("R7 confirm after ignored setup", lock_bits, exp_lock);
        chk("R7 status unchanged", NB'(status_reg), NB'(8'h80));
        suspended = 1'b1;
        wr(blk_addr(30), 8'h60);
        suspended = 1'b0;
        chk("R7 setup ignored while suspended", NB'(rd_status_sel), NB'(0));

        // R11 confirm while suspended
        wr(blk_addr(30), 8'h60);
        suspended = 1'b1;
        wr(blk_addr(30), 8'h01);
        suspended = 1'b0;
        chk("R11 status sequence error", NB'(status_reg), NB'(8'hB0));
        chk("R11 lock unchanged", lock_bits, exp_lock);

        // R10 clear status
        wr(blk_addr(0), 8'h50);
        chk("R10 clear status", NB'(status_reg), NB'(8'h80));

        done = 1'b1;
        finish_run();
    end

endmodule